// File: doc/BRIEF.md
# Dual-FIFO Card Data Transmitter

This block sends one block of data to a memory card over a single serial data line. Software loads bytes through a byte-wide write port into a pair of 8-byte storage halves that work as a ping-pong pair. Before a block starts, both halves are filled (16 bytes). Once the enable input is raised, the block sends a low start bit, then the data bytes most significant bit first, then a 16-bit CRC over the data, then a high end bit. Each bit lasts a fixed number of clock cycles set by a divider parameter.

As each half is drained, its own empty flag rises so software can refill that half with 8 more bytes. An interrupt request combines the two flags with two separate mask inputs. If the next byte is needed and none is stored, the line returns high and an underrun status is held. Clearing the enable input ends the block, discards stored bytes and returns the block to idle. The block length is given in units of 8-byte halves.

Top module: `dual_fifo_card_tx`

## Requirements
- R1: After reset the line is high and the empty flags, interrupt request, underrun status and busy output are all 0.
- R2: A block starts only when the enable input is 1, the direction input is 1, the block length is nonzero and the first half holds 8 bytes; it starts with a single start bit of 0 lasting CLK_DIV cycles, and busy rises in the same cycle the line falls.
- R3: Data bytes follow the start bit most significant bit first, each bit lasting CLK_DIV cycles, in the order they were written; halves drain alternately, half A first.
- R4: After the last data byte the block sends 16 CRC bits, most significant first, of the CRC over all data bits with polynomial x^16+x^12+x^5+1 (0x1021) and initial value 0, then one end bit of 1; the line then stays high and busy is 0.
- R5: Writes fill half A with 8 bytes, then half B, alternating; a write that targets a half still holding 8 bytes is dropped. A half's empty flag rises when its last byte is taken for sending.
- R6: An empty flag is cleared by a one-cycle pulse on its clear input or by a write that lands in that half; if a flag is set and cleared in the same cycle, it is set.
- R7: The interrupt request is 1 exactly when an empty flag is 1 and its mask input is 0; with both masks 1 it stays 0.
- R8: While the direction input is 0, writes are ignored and no block starts.
- R9: If a byte is needed and the half to drain does not hold 8 bytes, the line goes high, busy falls, no CRC is sent and underrun stays 1 until the enable input is cleared.
- R10: Clearing the enable input at any time ends the block within one cycle (busy 0, line high) and discards all stored bytes, so the next block sends only bytes written after that.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| txEnable | input | 1 | Data enable; 1 starts and holds a block, 0 ends it |
| dirTx | input | 1 | Direction; 1 selects transmit |
| blkHalves | input | HALVES_W | Block length in 8-byte halves |
| wrEn | input | 1 | Byte write strobe |
| wrData | input | DATA_W | Byte to store |
| maskA | input | 1 | Interrupt mask for half A empty flag (1 masks) |
| maskB | input | 1 | Interrupt mask for half B empty flag (1 masks) |
| clrA | input | 1 | Clear pulse for half A empty flag |
| clrB | input | 1 | Clear pulse for half B empty flag |
| lineOut | output | 1 | Serial data line to the card |
| emptyA | output | 1 | Half A empty flag |
| emptyB | output | 1 | Half B empty flag |
| irq | output | 1 | Interrupt request |
| underrun | output | 1 | Underrun status |
| busy | output | 1 | Block being sent (start to end bit) |

## Verification
The two functions that can meet in one cycle are the setting of a half's empty flag, when its last byte is taken, and the software clear of that same flag. The bench holds the clear input of half A high for a whole block, so the clear is present in the exact cycle the drain sets the flag. The set must win: the flag has to be seen high for at least one sampled cycle and be low again after the block, while half B's flag, not cleared, stays high.

// File: rtl/dfct_pkg.sv
package dfct_pkg;

  localparam int CRC_W = 16;
  localparam logic [CRC_W-1:0] CRC_POLY = 16'h1021;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DATA,
    ST_CRC,
    ST_END,
    ST_DONE,
    ST_UNDER
  } txState_t;

  // strobes from control to datapath and storage
  typedef struct packed {
    logic sendStart;
    logic sendData;
    logic takeByte;
    logic sendCrc;
    logic sendIdle;
    logic flush;
  } txStrobe_t;

  function automatic logic [CRC_W-1:0] crcStep(input logic [CRC_W-1:0] cur, input logic bitIn);
    logic fb;
    fb = bitIn ^ cur[CRC_W-1];
    return {cur[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
  endfunction

endpackage

// File: rtl/dfct_fifo_pair.sv
module dfct_fifo_pair #(
  parameter int DATA_W     = 8,
  parameter int HALF_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              dirTx,
  input  logic              clrA,
  input  logic              clrB,
  input  logic              pop,
  input  logic              flush,
  output logic [DATA_W-1:0] headByte,
  output logic              headValid,
  output logic              emptyA,
  output logic              emptyB
);

  localparam int PTR_W = (HALF_DEPTH > 1) ? $clog2(HALF_DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(HALF_DEPTH - 1);

  logic [DATA_W-1:0] store [2][HALF_DEPTH];
  logic [1:0]        halfFull;
  logic              fillSel, drainSel;
  logic [PTR_W-1:0]  fillIdx, drainIdx;
  logic              wrAccept, popLast;
  logic [1:0]        clrIn, flagQ;

  assign wrAccept  = wrEn && dirTx && !halfFull[fillSel];
  assign headValid = halfFull[drainSel];
  assign headByte  = store[drainSel][drainIdx];
  assign popLast   = pop && headValid && (drainIdx == LAST_IDX);
  assign clrIn     = {clrB, clrA};

  always_ff @(posedge clk) begin
    if (wrAccept) store[fillSel][fillIdx] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN || flush) begin
      halfFull <= '0;
      fillSel  <= 1'b0;
      drainSel <= 1'b0;
      fillIdx  <= '0;
      drainIdx <= '0;
    end else begin
      if (wrAccept) begin
        if (fillIdx == LAST_IDX) begin
          fillIdx           <= '0;
          fillSel           <= !fillSel;
          halfFull[fillSel] <= 1'b1;
        end else begin
          fillIdx <= fillIdx + PTR_W'(1);
        end
      end
      if (pop && headValid) begin
        if (drainIdx == LAST_IDX) begin
          drainIdx           <= '0;
          drainSel           <= !drainSel;
          halfFull[drainSel] <= 1'b0;
        end else begin
          drainIdx <= drainIdx + PTR_W'(1);
        end
      end
    end
  end

  // empty flags: drain sets, software clear or refill clears, set wins
  for (genvar h = 0; h < 2; h++) begin : g_flag
    logic setF, clrF, q;
    assign setF = popLast && (drainSel == 1'(h));
    assign clrF = clrIn[h] || (wrAccept && (fillSel == 1'(h)));
    always_ff @(posedge clk) begin
      if (!rstN)     q <= 1'b0;
      else if (setF) q <= 1'b1;
      else if (clrF) q <= 1'b0;
    end
    assign flagQ[h] = q;
  end

  assign emptyA = flagQ[0];
  assign emptyB = flagQ[1];

endmodule

// File: rtl/dfct_ctrl.sv
module dfct_ctrl
  import dfct_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int HALF_DEPTH = 8,
  parameter int CLK_DIV    = 4,
  parameter int HALVES_W   = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                txEnable,
  input  logic                dirTx,
  input  logic [HALVES_W-1:0] blkHalves,
  input  logic                headValid,
  output txStrobe_t           strobe,
  output logic                busy,
  output logic                underrun
);

  localparam int BIT_W  = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam int CNT_W  = HALVES_W + $clog2(HALF_DEPTH) + 1;
  localparam int CRCI_W = $clog2(CRC_W);
  localparam logic [BIT_W-1:0]  LAST_BIT = BIT_W'(DATA_W - 1);
  localparam logic [CRCI_W-1:0] LAST_CRC = CRCI_W'(CRC_W - 1);

  logic tick;

  generate
    if (CLK_DIV <= 1) begin : g_nodiv
      assign tick = 1'b1;
    end else begin : g_div
      localparam int DIV_W = $clog2(CLK_DIV);
      localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_DIV - 1);
      logic [DIV_W-1:0] divCnt;
      always_ff @(posedge clk) begin
        if (!rstN)                divCnt <= '0;
        else if (divCnt == DIV_LAST) divCnt <= '0;
        else                      divCnt <= divCnt + DIV_W'(1);
      end
      assign tick = (divCnt == DIV_LAST);
    end
  endgenerate

  txState_t          state, nextState;
  logic [BIT_W-1:0]  bitIdx;
  logic [CNT_W-1:0]  byteCnt, totalBytes;
  logic [CRCI_W-1:0] crcIdx;
  logic              lastByte, bitLast, canStart;

  assign totalBytes = CNT_W'(blkHalves) * CNT_W'(HALF_DEPTH);
  assign lastByte   = (byteCnt == totalBytes - CNT_W'(1));
  assign bitLast    = (bitIdx == LAST_BIT);
  assign canStart   = txEnable && dirTx && (blkHalves != '0) && headValid;

  always_comb begin
    strobe    = '0;
    nextState = state;
    if (state != ST_IDLE && !txEnable) begin
      strobe.sendIdle = 1'b1;
      strobe.flush    = 1'b1;
      nextState       = ST_IDLE;
    end else if (tick) begin
      case (state)
        ST_IDLE: begin
          if (canStart) begin
            strobe.sendStart = 1'b1;
            nextState        = ST_DATA;
          end
        end
        ST_DATA: begin
          if (bitIdx == '0 && !headValid) begin
            strobe.sendIdle = 1'b1;
            nextState       = ST_UNDER;
          end else begin
            strobe.sendData = 1'b1;
            strobe.takeByte = (bitIdx == '0);
            if (bitLast && lastByte) nextState = ST_CRC;
          end
        end
        ST_CRC: begin
          strobe.sendCrc = 1'b1;
          if (crcIdx == LAST_CRC) nextState = ST_END;
        end
        ST_END: begin
          strobe.sendIdle = 1'b1;
          nextState       = ST_DONE;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      bitIdx  <= '0;
      byteCnt <= '0;
      crcIdx  <= '0;
    end else begin
      state <= nextState;
      if (strobe.flush || strobe.sendStart) begin
        bitIdx  <= '0;
        byteCnt <= '0;
        crcIdx  <= '0;
      end else if (strobe.sendData) begin
        bitIdx <= bitLast ? '0 : bitIdx + BIT_W'(1);
        if (bitLast) byteCnt <= byteCnt + CNT_W'(1);
      end else if (strobe.sendCrc) begin
        crcIdx <= crcIdx + CRCI_W'(1);
      end
    end
  end

  assign busy     = (state == ST_DATA) || (state == ST_CRC) || (state == ST_END);
  assign underrun = (state == ST_UNDER);

endmodule

// File: rtl/dfct_datapath.sv
module dfct_datapath
  import dfct_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  txStrobe_t         strobe,
  input  logic [DATA_W-1:0] headByte,
  output logic              lineOut
);

  logic [DATA_W-1:0] shiftReg, shSrc;
  logic [CRC_W-1:0]  crcReg;
  logic              bitVal;

  assign shSrc  = strobe.takeByte ? headByte : shiftReg;
  assign bitVal = shSrc[DATA_W-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lineOut  <= 1'b1;
      shiftReg <= '0;
      crcReg   <= '0;
    end else if (strobe.sendIdle) begin
      lineOut <= 1'b1;
    end else if (strobe.sendStart) begin
      lineOut <= 1'b0;
      crcReg  <= '0;
    end else if (strobe.sendData) begin
      lineOut  <= bitVal;
      shiftReg <= {shSrc[DATA_W-2:0], 1'b0};
      crcReg   <= crcStep(crcReg, bitVal);
    end else if (strobe.sendCrc) begin
      lineOut <= crcReg[CRC_W-1];
      crcReg  <= {crcReg[CRC_W-2:0], 1'b0};
    end
  end

endmodule

// File: rtl/dual_fifo_card_tx.sv
module dual_fifo_card_tx
  import dfct_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int HALF_DEPTH = 8,
  parameter int CLK_DIV    = 4,
  parameter int HALVES_W   = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                txEnable,
  input  logic                dirTx,
  input  logic [HALVES_W-1:0] blkHalves,
  input  logic                wrEn,
  input  logic [DATA_W-1:0]   wrData,
  input  logic                maskA,
  input  logic                maskB,
  input  logic                clrA,
  input  logic                clrB,
  output logic                lineOut,
  output logic                emptyA,
  output logic                emptyB,
  output logic                irq,
  output logic                underrun,
  output logic                busy
);

  txStrobe_t         strobe;
  logic [DATA_W-1:0] headByte;
  logic              headValid;

  dfct_fifo_pair #(.DATA_W(DATA_W), .HALF_DEPTH(HALF_DEPTH)) u_fifo (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .dirTx(dirTx),
    .clrA(clrA), .clrB(clrB), .pop(strobe.takeByte), .flush(strobe.flush),
    .headByte(headByte), .headValid(headValid), .emptyA(emptyA), .emptyB(emptyB)
  );

  dfct_ctrl #(.DATA_W(DATA_W), .HALF_DEPTH(HALF_DEPTH), .CLK_DIV(CLK_DIV),
              .HALVES_W(HALVES_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .txEnable(txEnable), .dirTx(dirTx),
    .blkHalves(blkHalves), .headValid(headValid), .strobe(strobe),
    .busy(busy), .underrun(underrun)
  );

  dfct_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .headByte(headByte), .lineOut(lineOut)
  );

  assign irq = (emptyA && !maskA) || (emptyB && !maskB);

endmodule

// File: rtl/dfct_checker.sv
module dfct_checker (
  input logic clk,
  input logic rstN,
  input logic txEnable,
  input logic dirTx,
  input logic maskA,
  input logic maskB,
  input logic lineOut,
  input logic emptyA,
  input logic emptyB,
  input logic irq,
  input logic underrun,
  input logic busy
);

  a_r2_start_low: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> !lineOut);

  a_r4_end_high: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> lineOut);

  a_r5_flag_a_in_block: assert property (@(posedge clk) disable iff (!rstN)
    $rose(emptyA) |-> busy);

  a_r5_flag_b_in_block: assert property (@(posedge clk) disable iff (!rstN)
    $rose(emptyB) |-> busy);

  a_r7_masked_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (maskA && maskB) |-> !irq);

  a_r8_no_start_rx: assert property (@(posedge clk) disable iff (!rstN)
    !dirTx |=> !$rose(busy));

  a_r9_underrun_idle: assert property (@(posedge clk) disable iff (!rstN)
    underrun |-> (lineOut && !busy));

  a_r10_abort: assert property (@(posedge clk) disable iff (!rstN)
    !txEnable |=> !busy);

endmodule

bind dual_fifo_card_tx dfct_checker u_chk (
  .clk(clk), .rstN(rstN), .txEnable(txEnable), .dirTx(dirTx),
  .maskA(maskA), .maskB(maskB), .lineOut(lineOut), .emptyA(emptyA),
  .emptyB(emptyB), .irq(irq), .underrun(underrun), .busy(busy)
);

// File: tb/dual_fifo_card_tx_bench.sv
module dual_fifo_card_tx_bench;

  localparam int DIV = 4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       txEnable = 1'b0, dirTx = 1'b1;
  logic [3:0] blkHalves = 4'd2;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic       maskA = 1'b1, maskB = 1'b1, clrA = 1'b0, clrB = 1'b0;
  logic       lineOut, emptyA, emptyB, irq, underrun, busy;

  int checks = 0;
  int errs = 0;
  logic [7:0]  expBytes [64];
  logic [7:0]  rxBytes  [64];
  logic [15:0] rxCrc;
  logic        rxEnd;
  logic        rxDone;

  always #4 clk = ~clk;

  dual_fifo_card_tx #(.CLK_DIV(DIV)) u_dual_fifo_card_tx (
    .clk(clk), .rstN(rstN), .txEnable(txEnable), .dirTx(dirTx), .blkHalves(blkHalves),
    .wrEn(wrEn), .wrData(wrData), .maskA(maskA), .maskB(maskB), .clrA(clrA), .clrB(clrB),
    .lineOut(lineOut), .emptyA(emptyA), .emptyB(emptyB), .irq(irq),
    .underrun(underrun), .busy(busy)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] refCrc(input int n);
    logic [15:0] c = '0;
    for (int i = 0; i < n; i++) begin
      for (int b = 7; b >= 0; b--) begin
        logic fb;
        fb = expBytes[i][b] ^ c[15];
        c = {c[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
      end
    end
    return c;
  endfunction

  task automatic writeByte(input logic [7:0] b);
    @(negedge clk);
    wrEn = 1'b1; wrData = b;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic writeRange(input int first, input int n);
    for (int i = first; i < first + n; i++) writeByte(expBytes[i]);
  endtask

  task automatic clearFlags();
    @(negedge clk);
    clrA = 1'b1; clrB = 1'b1;
    @(negedge clk);
    clrA = 1'b0; clrB = 1'b0;
  endtask

  task automatic sampleBit(output logic v);
    repeat (DIV) @(posedge clk);
    @(negedge clk);
    v = lineOut;
  endtask

  task automatic rxFrame(input int n, input string tag);
    int guard = 0;
    logic v;
    @(negedge clk);
    while (lineOut !== 1'b0 && guard < 20000) begin
      @(negedge clk);
      guard++;
    end
    check(guard < 20000, {tag, " start bit seen"}, guard, 0);
    check(busy === 1'b1, {tag, " busy with start bit R2"}, busy, 1);
    for (int i = 0; i < n; i++) begin
      for (int b = 0; b < 8; b++) begin
        sampleBit(v);
        rxBytes[i] = {rxBytes[i][6:0], v};
      end
    end
    for (int b = 0; b < 16; b++) begin
      sampleBit(v);
      rxCrc = {rxCrc[14:0], v};
    end
    sampleBit(rxEnd);
  endtask

  task automatic compareFrame(input int n, input string tag);
    int bad = 0;
    for (int i = 0; i < n; i++) begin
      if (rxBytes[i] !== expBytes[i]) begin
        if (bad == 0) check(1'b0, {tag, " data byte R3"}, rxBytes[i], expBytes[i]);
        bad++;
      end
    end
    if (bad == 0) check(1'b1, {tag, " data R3"}, 0, 0);
    check(rxCrc === refCrc(n), {tag, " crc R4"}, rxCrc, refCrc(n));
    check(rxEnd === 1'b1, {tag, " end bit R4"}, rxEnd, 1);
  endtask

  // R1
  task automatic testReset();
    @(negedge clk);
    check(lineOut === 1'b1 && busy === 1'b0, "R1 line/busy", {lineOut, busy}, 2'b10);
    check(emptyA === 1'b0 && emptyB === 1'b0 && irq === 1'b0 && underrun === 1'b0,
          "R1 flags", {emptyA, emptyB, irq, underrun}, 0);
  endtask

  // R8: direction 0 ignores writes and start
  task automatic testDirection();
    dirTx = 1'b0; blkHalves = 4'd2;
    for (int i = 0; i < 16; i++) expBytes[i] = 8'(i + 1);
    writeRange(0, 16);
    @(negedge clk); txEnable = 1'b1;
    repeat (40) @(negedge clk);
    check(busy === 1'b0 && lineOut === 1'b1, "R8 no start while dir 0", {busy, lineOut}, 2'b01);
    dirTx = 1'b1;
    repeat (40) @(negedge clk);
    check(busy === 1'b0, "R8 writes with dir 0 dropped", busy, 0);
    txEnable = 1'b0;
    @(negedge clk);
  endtask

  // R2 R3 R4 R5 R6 R7: 32-byte block with refills
  task automatic testRefill();
    clearFlags();
    maskA = 1'b0; maskB = 1'b1; blkHalves = 4'd4;
    for (int i = 0; i < 32; i++) expBytes[i] = 8'(i * 37 + 5);
    writeRange(0, 16);
    writeByte(8'hEE);
    repeat (20) @(negedge clk);
    check(busy === 1'b0, "R2 no start before enable", busy, 0);
    txEnable = 1'b1;
    fork
      rxFrame(32, "refill");
      begin
        wait (emptyA === 1'b1);
        @(negedge clk);
        check(irq === 1'b1, "R7 irq from unmasked flag A", irq, 1);
        writeRange(16, 1);
        check(emptyA === 1'b0, "R6 write clears flag A", emptyA, 0);
        writeRange(17, 7);
        wait (emptyB === 1'b1);
        @(negedge clk);
        check(irq === 1'b0, "R7 masked flag B no irq", irq, 0);
        check(emptyB === 1'b1, "R5 flag B set after drain", emptyB, 1);
        clrB = 1'b1;
        @(negedge clk);
        clrB = 1'b0;
        check(emptyB === 1'b0, "R6 clear pulse clears flag B", emptyB, 0);
        writeRange(24, 8);
      end
    join
    compareFrame(32, "refill R5 extra byte dropped");
    check(busy === 1'b0, "R4 busy low after end", busy, 0);
    repeat (3 * DIV) @(negedge clk);
    check(lineOut === 1'b1, "R4 line high after block", lineOut, 1);
    txEnable = 1'b0;
    maskA = 1'b1;
    @(negedge clk);
  endtask

  // R6: flag set and clear in the same cycle
  task automatic testSetWins();
    int seenA = 0;
    clearFlags();
    blkHalves = 4'd2;
    for (int i = 0; i < 16; i++) expBytes[i] = (i % 2 == 0) ? 8'hFF : 8'(i * 17);
    writeRange(0, 16);
    @(negedge clk);
    clrA = 1'b1; txEnable = 1'b1;
    rxDone = 1'b0;
    fork
      begin rxFrame(16, "setwins"); rxDone = 1'b1; end
      begin
        while (!rxDone) begin
          @(negedge clk);
          if (emptyA === 1'b1) seenA++;
        end
      end
    join
    compareFrame(16, "setwins");
    check(seenA >= 1, "R6 set wins over clear flag A", seenA, 1);
    check(emptyA === 1'b0 && emptyB === 1'b1, "R6 flags after block", {emptyA, emptyB}, 2'b01);
    clrA = 1'b0; txEnable = 1'b0;
    @(negedge clk);
  endtask

  // R9: underrun
  task automatic testUnderrun();
    int guard = 0;
    clearFlags();
    blkHalves = 4'd4;
    for (int i = 0; i < 16; i++) expBytes[i] = 8'(8'h3C ^ i);
    writeRange(0, 16);
    @(negedge clk); txEnable = 1'b1;
    while (underrun !== 1'b1 && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    check(underrun === 1'b1, "R9 underrun raised", underrun, 1);
    check(busy === 1'b0 && lineOut === 1'b1, "R9 line idle on underrun", {busy, lineOut}, 2'b01);
    repeat (20 * DIV) @(negedge clk);
    check(underrun === 1'b1 && lineOut === 1'b1, "R9 underrun held, no crc", {underrun, lineOut}, 2'b11);
    txEnable = 1'b0;
    @(negedge clk);
    check(underrun === 1'b0, "R9 underrun clears with enable", underrun, 0);
  endtask

  // R10: abort and flush
  task automatic testAbort();
    clearFlags();
    blkHalves = 4'd2;
    for (int i = 0; i < 16; i++) expBytes[i] = 8'(8'hA0 + i);
    writeRange(0, 16);
    @(negedge clk); txEnable = 1'b1;
    wait (busy === 1'b1);
    repeat (50) @(negedge clk);
    txEnable = 1'b0;
    @(negedge clk);
    check(busy === 1'b0 && lineOut === 1'b1, "R10 abort within one cycle", {busy, lineOut}, 2'b01);
    for (int i = 0; i < 16; i++) expBytes[i] = 8'(8'h50 + 3 * i);
    writeRange(0, 16);
    @(negedge clk); txEnable = 1'b1;
    rxFrame(16, "after abort R10");
    compareFrame(16, "after abort R10");
    txEnable = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 190000, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testDirection();
    testRefill();
    testSetWins();
    testUnderrun();
    testAbort();
    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end

endmodule